// File: doc/BRIEF.md
# JTAG Debug Burst Read Responder

This block is the target end of a debug burst read, and it runs entirely on the test clock. A host shifts a 53-bit command into the data register. On Update-DR the block decodes the command and starts fetching consecutive words through a single-outstanding request/acknowledge bus port. In the next Shift-DR session the host pulls the words out on TDO. Before each word the block sends status bits: a 0 for every shift in which no word is ready yet, then one 1. The word follows, least significant bit first.

After the last word the block shifts out a 32-bit CRC of every data bit it sent. A sticky error register records the first bus access that failed. A failed access still yields a word, forced to zero, so that the host's bit count stays aligned with the stream. Two extra opcodes let the host read the error register and clear it over the same data register.

The TAP state machine lives outside the block. It supplies one-cycle `update_dr_i` pulses and level `shift_dr_i`, and the two are never high together.

Top module: `jdbg_burst_reader`

## Requirements
- R1: After reset `tdo_o` and `bus_req_o` are 0 and the block waits for a command.
- R2: A command frame is shifted LSB first and has these fields: bits 15:0 word count, bits 47:16 start address, bits 51:48 opcode, bit 52 module-select. A frame with bit 52 set is ignored on Update-DR. It starts no bus request, drives only 0 on TDO and leaves the error register unchanged.
- R3: Opcode 1 reads 8-bit words, opcode 2 reads 16-bit words and opcode 3 reads 32-bit words. Each word is the low 8, 16 or 32 bits of read data, sent in that many bits, and the address advances by 1, 2 or 4 per word. `bus_size_o` carries 0, 1 or 2 for these three sizes.
- R4: For each word the block shifts a 0 status bit in every shift cycle in which no word is buffered, then a single 1, then the word LSB first. The first fetch starts in the cycle after Update-DR. Each later fetch starts in the cycle after the 1 status bit. So for a bus latency of L cycles the first word is preceded by L zeros and each later word by max(0, L - word bits) zeros.
- R5: The first request goes to the start address, and exactly as many words are delivered as the count field gives. A request holds its address until it is acknowledged or errored.
- R6: After the last word, 32 CRC bits are shifted LSB first. The CRC starts at all ones. For each data bit sent it shifts right and XORs 0xEDB88320 when the data bit differs from the CRC's bit 0. There is no final inversion.
- R7: A bus error response sets the error flag and captures the failing address when the flag is clear. The affected word is sent as zero, and the burst continues to its end.
- R8: While the flag is set, later bus errors change neither the flag nor the captured address.
- R9: Opcode 8 writes the error register: frame bit 0 set to 1 clears flag and address, and frame bit 0 set to 0 has no effect.
- R10: Opcode 9 makes the next Shift-DR session return 33 bits LSB first: bit 0 is the flag and bits 32:1 are the captured address.
- R11: A read command with word count 0 starts no bus request.
- R12: After the CRC trailer, TDO stays 0 until the next Update-DR ends the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shift_dr_i | input | 1 | TAP is in Shift-DR this cycle |
| update_dr_i | input | 1 | One-cycle Update-DR pulse |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, valid for the current shift cycle |
| bus_req_o | output | 1 | Read request, held until response |
| bus_addr_o | output | 32 | Read address |
| bus_size_o | output | 2 | Access size code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit) |
| bus_ack_i | input | 1 | Read completed, data valid |
| bus_err_i | input | 1 | Read failed |
| bus_rdata_i | input | 32 | Read data |

## Verification
A bus acknowledge can arrive on the same clock edge on which the host consumes a 0 status bit. The design must report that bit as 0 and offer the 1 on the very next shift. The bench drives the bus model with a chosen latency and shifts continuously from the cycle after Update-DR. This makes the last wait cycle coincide with the acknowledge for every burst in the vector table. It then compares the exact number of zeros before each word with the count derived from the latency and the word width. Because a missing or doubled status bit would also shift every later data bit, the word and CRC comparisons that follow judge the same event a second time.

// File: rtl/jdbg_burst_pkg.sv
package jdbg_burst_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_RD8    = 4'h1;
  localparam logic [OP_W-1:0] OP_RD16   = 4'h2;
  localparam logic [OP_W-1:0] OP_RD32   = 4'h3;
  localparam logic [OP_W-1:0] OP_ERR_WR = 4'h8;
  localparam logic [OP_W-1:0] OP_ERR_RD = 4'h9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STAT, ST_DATA, ST_CRC, ST_TAIL, ST_ERRD
  } st_e;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2
  } size_e;
endpackage

// File: rtl/jdbg_crc.sv
module jdbg_crc #(
  parameter int              CRC_W = 32,
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             upd_i,
  input  logic             bit_i,
  input  logic             shift_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '1;
    else if (init_i) crc_q <= '1;
    else if (upd_i) crc_q <= {1'b0, crc_q[CRC_W-1:1]} ^ ((bit_i ^ crc_q[0]) ? POLY : '0);
    else if (shift_i) crc_q <= {1'b0, crc_q[CRC_W-1:1]};
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/jdbg_err_reg.sv
module jdbg_err_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      addr_o <= '0;
    end else if (clr_i) begin
      // an error landing with the clear is kept, not lost
      flag_o <= set_i;
      addr_o <= set_i ? set_addr_i : '0;
    end else if (set_i && !flag_o) begin
      flag_o <= 1'b1;
      addr_o <= set_addr_i;
    end
  end
endmodule

// File: rtl/jdbg_fetch.sv
module jdbg_fetch
  import jdbg_burst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  size_e             size_i,
  input  logic              take_i,
  input  logic              abort_i,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_size_o,
  input  logic              bus_ack_i,
  input  logic              bus_err_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              word_vld_o,
  output logic [DATA_W-1:0] word_o,
  output logic              err_set_o
);
  size_e             size_q;
  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] step;
  logic [DATA_W-1:0] masked;
  logic              resp;

  always_comb begin
    case (size_q)
      SZ_8:    begin step = ADDR_W'(1); masked = DATA_W'(bus_rdata_i[7:0]);  end
      SZ_16:   begin step = ADDR_W'(2); masked = DATA_W'(bus_rdata_i[15:0]); end
      default: begin step = ADDR_W'(4); masked = bus_rdata_i;                end
    endcase
  end

  assign resp = bus_req_o && (bus_ack_i || bus_err_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q     <= SZ_32;
      left_q     <= '0;
      bus_req_o  <= 1'b0;
      bus_addr_o <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else if (start_i) begin
      size_q     <= size_i;
      left_q     <= cnt_i;
      bus_addr_o <= addr_i;
      bus_req_o  <= 1'b1;
      word_vld_o <= 1'b0;
    end else begin
      if (resp) begin
        bus_req_o  <= 1'b0;
        word_vld_o <= 1'b1;
        word_o     <= bus_err_i ? '0 : masked;
        bus_addr_o <= bus_addr_o + step;
        left_q     <= left_q - CNT_W'(1);
      end else if (take_i) begin
        word_vld_o <= 1'b0;
        if (left_q != '0 && !abort_i) bus_req_o <= 1'b1;
      end
      if (abort_i) left_q <= '0;
    end
  end

  assign bus_size_o = size_q;
  assign err_set_o  = bus_req_o && bus_err_i;
endmodule

// File: rtl/jdbg_burst_reader.sv
module jdbg_burst_reader
  import jdbg_burst_pkg::*;
#(
  parameter int               ADDR_W   = 32,
  parameter int               CNT_W    = 16,
  parameter int               DATA_W   = 32,
  parameter int               CRC_W    = 32,
  parameter logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_dr_i,
  input  logic              update_dr_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_size_o,
  input  logic              bus_ack_i,
  input  logic              bus_err_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  localparam int FRAME_W = 1 + OP_W + ADDR_W + CNT_W;
  localparam int MAX_B   = (CRC_W > ADDR_W + 1) ? CRC_W : ADDR_W + 1;
  localparam int BIT_W   = $clog2(MAX_B) + 1;

  logic [FRAME_W-1:0] sreg;
  st_e                st;
  size_e              size_q, dec_size;
  logic [CNT_W-1:0]   words_left;
  logic [BIT_W-1:0]   bitcnt, wbits;
  logic [DATA_W-1:0]  shifter;
  logic [ADDR_W:0]    errsh;

  logic              f_sel;
  logic [OP_W-1:0]   f_op;
  logic [ADDR_W-1:0] f_addr;
  logic [CNT_W-1:0]  f_cnt;
  logic              dec_ok, is_rd, start, err_clr, err_rd_go, abort;

  logic              word_vld, take, err_set, err_flag;
  logic [DATA_W-1:0] word_data;
  logic [ADDR_W-1:0] err_addr;
  logic [CRC_W-1:0]  crc;

  // command shift register, LSB arrives first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sreg <= '0;
    else if (shift_dr_i) sreg <= {tdi_i, sreg[FRAME_W-1:1]};
  end

  assign f_sel  = sreg[FRAME_W-1];
  assign f_op   = sreg[FRAME_W-2 -: OP_W];
  assign f_addr = sreg[CNT_W +: ADDR_W];
  assign f_cnt  = sreg[CNT_W-1:0];

  always_comb begin
    dec_ok    = update_dr_i && (st == ST_IDLE) && !f_sel;
    is_rd     = (f_op == OP_RD8) || (f_op == OP_RD16) || (f_op == OP_RD32);
    start     = dec_ok && is_rd && (f_cnt != '0);
    err_clr   = dec_ok && (f_op == OP_ERR_WR) && sreg[0];
    err_rd_go = dec_ok && (f_op == OP_ERR_RD);
    abort     = update_dr_i && (st != ST_IDLE);
    case (f_op)
      OP_RD8:  dec_size = SZ_8;
      OP_RD16: dec_size = SZ_16;
      default: dec_size = SZ_32;
    endcase
    case (size_q)
      SZ_8:    wbits = BIT_W'(8);
      SZ_16:   wbits = BIT_W'(16);
      default: wbits = BIT_W'(32);
    endcase
  end

  assign take = (st == ST_STAT) && shift_dr_i && word_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= ST_IDLE;
      size_q     <= SZ_32;
      words_left <= '0;
      bitcnt     <= '0;
      shifter    <= '0;
      errsh      <= '0;
    end else if (st == ST_IDLE) begin
      if (start) begin
        st         <= ST_STAT;
        size_q     <= dec_size;
        words_left <= f_cnt;
        bitcnt     <= '0;
      end else if (err_rd_go) begin
        st    <= ST_ERRD;
        errsh <= {err_addr, err_flag};
      end
    end else if (update_dr_i) begin
      st <= ST_IDLE;
    end else if (shift_dr_i) begin
      case (st)
        ST_STAT: if (word_vld) begin
          st      <= ST_DATA;
          shifter <= word_data;
          bitcnt  <= '0;
        end
        ST_DATA: begin
          shifter <= shifter >> 1;
          bitcnt  <= bitcnt + BIT_W'(1);
          if (bitcnt == wbits - BIT_W'(1)) begin
            bitcnt     <= '0;
            words_left <= words_left - CNT_W'(1);
            st         <= (words_left == CNT_W'(1)) ? ST_CRC : ST_STAT;
          end
        end
        ST_CRC: begin
          bitcnt <= bitcnt + BIT_W'(1);
          if (bitcnt == BIT_W'(CRC_W - 1)) st <= ST_TAIL;
        end
        ST_ERRD: errsh <= errsh >> 1;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_STAT: tdo_o = word_vld;
      ST_DATA: tdo_o = shifter[0];
      ST_CRC:  tdo_o = crc[0];
      ST_ERRD: tdo_o = errsh[0];
      default: tdo_o = 1'b0;
    endcase
  end

  jdbg_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .addr_i      (f_addr),
    .cnt_i       (f_cnt),
    .size_i      (dec_size),
    .take_i      (take),
    .abort_i     (abort),
    .bus_req_o   (bus_req_o),
    .bus_addr_o  (bus_addr_o),
    .bus_size_o  (bus_size_o),
    .bus_ack_i   (bus_ack_i),
    .bus_err_i   (bus_err_i),
    .bus_rdata_i (bus_rdata_i),
    .word_vld_o  (word_vld),
    .word_o      (word_data),
    .err_set_o   (err_set)
  );

  jdbg_crc #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (start),
    .upd_i   ((st == ST_DATA) && shift_dr_i && !update_dr_i),
    .bit_i   (shifter[0]),
    .shift_i ((st == ST_CRC) && shift_dr_i && !update_dr_i),
    .crc_o   (crc)
  );

  jdbg_err_reg #(.ADDR_W(ADDR_W)) u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (err_set),
    .set_addr_i (bus_addr_o),
    .clr_i      (err_clr),
    .flag_o     (err_flag),
    .addr_o     (err_addr)
  );
endmodule

// File: rtl/jdbg_burst_chk.sv
module jdbg_burst_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              update_dr_i,
  input logic              tdo_o,
  input logic              bus_req_o,
  input logic              bus_ack_i,
  input logic              bus_err_i,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              err_flag_i,
  input logic [ADDR_W-1:0] err_addr_i,
  input logic              err_clr_i,
  input logic              idle_i,
  input logic              sel_bit_i,
  input logic              in_data_i
);
  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i && !bus_err_i |=> bus_req_o && $stable(bus_addr_o));

  p_err_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_err_i && !err_flag_i && !err_clr_i
      |=> err_flag_i && (err_addr_i == $past(bus_addr_o)));

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flag_i && !err_clr_i |=> err_flag_i && $stable(err_addr_i));

  p_err_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && !(bus_req_o && bus_err_i) |=> !err_flag_i);

  p_select_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_dr_i && idle_i && sel_bit_i |=> idle_i);

  p_status_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_data_i) |-> $past(tdo_o));
endmodule

bind jdbg_burst_reader jdbg_burst_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .update_dr_i (update_dr_i),
  .tdo_o       (tdo_o),
  .bus_req_o   (bus_req_o),
  .bus_ack_i   (bus_ack_i),
  .bus_err_i   (bus_err_i),
  .bus_addr_o  (bus_addr_o),
  .err_flag_i  (err_flag),
  .err_addr_i  (err_addr),
  .err_clr_i   (err_clr),
  .idle_i      (st == ST_IDLE),
  .sel_bit_i   (f_sel),
  .in_data_i   (st == ST_DATA)
);

// File: tb/sim_jdbg_burst_reader.sv
`timescale 1ns/1ps
module sim_jdbg_burst_reader;
  localparam logic [3:0] RD8 = 4'h1, RD16 = 4'h2, RD32 = 4'h3, EWR = 4'h8, ERD = 4'h9;
  localparam logic [31:0] POLY = 32'hEDB88320;
  localparam int NV = 5;
  // op, addr, count, bus latency
  localparam logic [59:0] VEC [NV] = '{
    {RD32, 32'h0000_1000, 16'd4, 8'd2},
    {RD16, 32'h0000_2002, 16'd3, 8'd20},
    {RD8,  32'h0000_3001, 16'd5, 8'd1},
    {RD32, 32'hFFFF_FFF0, 16'd3, 8'd40},
    {RD8,  32'h0000_0010, 16'd1, 8'd9}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic tdo, bus_req, bus_ack = 1'b0, bus_err = 1'b0;
  logic [31:0] bus_addr, bus_rdata = '0;
  logic [1:0]  bus_size;

  int n_chk = 0, n_fail = 0, n_req = 0;
  int bus_lat = 1, lat_cnt = 0;
  logic inj_en = 1'b0;
  logic [31:0] inj_addr = '0;
  logic req_q = 1'b0;

  always #5 clk = ~clk;

  jdbg_burst_reader u0 (
    .clk_i(clk), .rst_ni(rst_n), .shift_dr_i(shift_dr), .update_dr_i(update_dr),
    .tdi_i(tdi), .tdo_o(tdo), .bus_req_o(bus_req), .bus_addr_o(bus_addr),
    .bus_size_o(bus_size), .bus_ack_i(bus_ack), .bus_err_i(bus_err), .bus_rdata_i(bus_rdata)
  );

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return a * 32'h9E37_79B1 + 32'h1234_5678;
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
    return {1'b0, c[31:1]} ^ ((b ^ c[0]) ? POLY : 32'h0);
  endfunction

  // bus responder: answers after bus_lat cycles of request
  always @(negedge clk) begin
    if (!bus_req) begin
      lat_cnt = 0; bus_ack = 1'b0; bus_err = 1'b0;
    end else begin
      lat_cnt = lat_cnt + 1;
      bus_rdata = mem_val(bus_addr);
      if (lat_cnt == bus_lat) begin
        if (inj_en && bus_addr == inj_addr) bus_err = 1'b1;
        else bus_ack = 1'b1;
      end else begin
        bus_ack = 1'b0; bus_err = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    if (bus_req && !req_q) n_req = n_req + 1;
    req_q = bus_req;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic shift_bit(output logic b);
    @(negedge clk); shift_dr = 1'b1; update_dr = 1'b0; tdi = 1'b0;
    #1 b = tdo;
  endtask

  task automatic pulse_update();
    @(negedge clk); shift_dr = 1'b0; update_dr = 1'b1; tdi = 1'b0;
  endtask

  task automatic idle_cycle();
    @(negedge clk); shift_dr = 1'b0; update_dr = 1'b0; tdi = 1'b0;
  endtask

  task automatic send_frame(input logic [52:0] f);
    for (int i = 0; i < 53; i++) begin
      @(negedge clk); shift_dr = 1'b1; update_dr = 1'b0; tdi = f[i];
    end
  endtask

  task automatic run_burst(input logic [3:0] op, input logic [31:0] a0,
                           input logic [15:0] cnt, input int lat);
    int w, zeros, exp_z;
    logic b;
    logic [31:0] crc, word, expw, wa;
    w = (op == RD8) ? 8 : (op == RD16) ? 16 : 32;
    bus_lat = lat;
    send_frame({1'b0, op, a0, cnt});
    pulse_update();
    crc = '1;
    for (int i = 0; i < cnt; i++) begin
      wa = a0 + i * (w / 8);
      zeros = 0; b = 1'b0;
      for (int g = 0; g < 100 && !b; g++) begin
        shift_bit(b);
        if (!b) zeros++;
      end
      exp_z = (i == 0) ? lat : ((lat > w) ? lat - w : 0);
      check("R4 status zeros before word", 64'(zeros), 64'(exp_z));
      word = '0;
      for (int k = 0; k < w; k++) begin shift_bit(b); word[k] = b; end
      if (inj_en && wa == inj_addr) begin
        expw = '0;
        check("R7 errored word sent as zero", 64'(word), 64'(expw));
      end else begin
        expw = (w == 8) ? {24'h0, mem_val(wa)[7:0]} :
               (w == 16) ? {16'h0, mem_val(wa)[15:0]} : mem_val(wa);
        check("R3 R5 word value and address", 64'(word), 64'(expw));
      end
      for (int k = 0; k < w; k++) crc = crc_step(crc, expw[k]);
    end
    word = '0;
    for (int k = 0; k < 32; k++) begin shift_bit(b); word[k] = b; end
    check("R6 CRC trailer", 64'(word), 64'(crc));
    word = '0;
    for (int k = 0; k < 4; k++) begin shift_bit(b); word[k] = b; end
    check("R12 zero after trailer", 64'(word), 64'(0));
    pulse_update();
    idle_cycle();
  endtask

  task automatic read_err(output logic [32:0] v);
    logic b;
    send_frame({1'b0, ERD, 32'h0, 16'h0});
    pulse_update();
    for (int k = 0; k < 33; k++) begin shift_bit(b); v[k] = b; end
    pulse_update();
    idle_cycle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [32:0] ev;
    logic b;
    int req0;
    // R1 reset state
    #12;
    check("R1 tdo in reset", 64'(tdo), 64'(0));
    check("R1 bus_req in reset", 64'(bus_req), 64'(0));
    @(negedge clk); rst_n = 1'b1;
    repeat (2) idle_cycle();
    check("R1 bus_req after reset", 64'(bus_req), 64'(0));

    for (int v = 0; v < NV; v++)
      run_burst(VEC[v][59:56], VEC[v][55:24], VEC[v][23:8], int'(VEC[v][7:0]));

    // R2 module-select frame ignored
    req0 = n_req;
    send_frame({1'b1, RD32, 32'h0000_4000, 16'd2});
    pulse_update();
    ev = '0;
    for (int k = 0; k < 10; k++) begin shift_bit(b); ev[k] = b; end
    idle_cycle();
    check("R2 select frame tdo", 64'(ev), 64'(0));
    check("R2 select frame no request", 64'(n_req - req0), 64'(0));

    // R11 zero count
    req0 = n_req;
    send_frame({1'b0, RD32, 32'h0000_5000, 16'd0});
    pulse_update();
    ev = '0;
    for (int k = 0; k < 5; k++) begin shift_bit(b); ev[k] = b; end
    idle_cycle();
    check("R11 zero count no request", 64'(n_req - req0), 64'(0));
    check("R11 zero count tdo", 64'(ev), 64'(0));

    // R7 bus error mid burst, burst continues
    inj_en = 1'b1; inj_addr = 32'h0000_6004;
    run_burst(RD32, 32'h0000_6000, 16'd3, 3);
    read_err(ev);
    check("R7 R10 error register after fault", 64'(ev), 64'({32'h0000_6004, 1'b1}));

    // R8 second error does not overwrite
    inj_addr = 32'h0000_7002;
    run_burst(RD16, 32'h0000_7000, 16'd2, 2);
    inj_en = 1'b0;
    read_err(ev);
    check("R8 sticky first address", 64'(ev), 64'({32'h0000_6004, 1'b1}));

    // R2 select frame carrying a clear is ignored
    send_frame({1'b1, EWR, 32'h0, 16'h0001});
    pulse_update();
    idle_cycle();
    read_err(ev);
    check("R2 select frame keeps error", 64'(ev), 64'({32'h0000_6004, 1'b1}));

    // R9 write with bit0=0 has no effect
    send_frame({1'b0, EWR, 32'h0, 16'h0002});
    pulse_update();
    idle_cycle();
    read_err(ev);
    check("R9 write zero keeps error", 64'(ev), 64'({32'h0000_6004, 1'b1}));

    // R9 write with bit0=1 clears
    send_frame({1'b0, EWR, 32'h0, 16'h0001});
    pulse_update();
    idle_cycle();
    read_err(ev);
    check("R9 R10 cleared register", 64'(ev), 64'(0));

    // clean burst after clear, error stays clear
    run_burst(RD32, 32'h0000_8000, 16'd2, 5);
    read_err(ev);
    check("R7 no error on clean burst", 64'(ev), 64'(0));

    summary();
  end
endmodule